// File: doc/BRIEF.md
# Windowed Watchdog Timer with Prescaler

This block watches system software by counting a slow, low-power tick. The tick passes through a prescaler that divides by 32 or by 128. A power-of-two postscaler follows it, with sixteen ratios from 1:1 to 1:32768. If software does not clear the count before the full period runs out, the block asks for a device reset. If the device is asleep or idle at that moment, it asks for a wake-up instead.

An optional fixed window makes a clear that comes too early count as a fault. A two-bit enable field sets the mode: always running, under software control, or off. The count restarts whenever any of these events occurs: a clear, a clock-switch completion, entry to sleep, or exit from sleep.

The slow tick arrives as a one-cycle strobe in the system clock domain. All strobes are single-cycle pulses in that domain.

Top module: `lp_watchdog`

## Requirements
- R1: `cfg_pre_long` sets the prescale divisor of the tick count: 0 divides by 32, 1 divides by 128.
- R2: `cfg_post_sel` = n sets a postscale ratio of 2^n. The period is (divisor × 2^n) ticks. A time-out raises a one-cycle output pulse in the cycle after the clock edge that takes the last tick, and the count then restarts from zero.
- R3: `cfg_en_mode` 2'b11 keeps the watchdog running, 2'b10 follows the software enable bit, and 2'b00 and 2'b01 keep it off. While it is off, no request is raised and the count is held at zero.
- R4: The software enable bit is loaded from `sw_en_d` when `sw_en_we` is high, and it is cleared by reset.
- R5: `osc_req_o` is high exactly when the watchdog is effectively enabled.
- R6: A clear (`kick_i`), sleep entry, sleep exit or clock-switch completion restarts the count, so the next time-out comes a full period after the strobe.
- R7: With `cfg_win_dis` = 0, a clear is accepted only once the postscale count has reached 3/4 of the ratio. An earlier clear raises a reset request and sets the flag, exactly as a time-out does.
- R8: With the 1:1 ratio (`cfg_post_sel` = 0) and the window on, the boundary is 3/4 of the prescale count: tick 24 of 32, or tick 96 of 128.
- R9: With `cfg_win_dis` = 1, a clear is accepted at any point and never raises a request.
- R10: A time-out while asleep (between a sleep entry and a sleep exit) raises `wake_req_o` and not `rst_req_o`.
- R11: `to_flag_o` is set by any time-out or early clear and holds until `flag_clr_i`. If a new event and a clear arrive together, the set wins.
- R12: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low device reset |
| lp_tick | input | 1 | Slow-oscillator tick strobe |
| cfg_pre_long | input | 1 | Prescale select (0: /32, 1: /128) |
| cfg_post_sel | input | SEL_W | Postscale exponent |
| cfg_en_mode | input | 2 | Enable mode field |
| cfg_win_dis | input | 1 | 1 disables the early-clear window |
| sw_en_we | input | 1 | Software enable write strobe |
| sw_en_d | input | 1 | Software enable write data |
| kick_i | input | 1 | Clear-watchdog strobe |
| sleep_enter_i | input | 1 | Sleep/idle entry strobe |
| sleep_exit_i | input | 1 | Sleep/idle exit strobe |
| clk_sw_done_i | input | 1 | Clock-switch-complete strobe |
| flag_clr_i | input | 1 | Software clear of the time-out flag |
| rst_req_o | output | 1 | One-cycle device reset request |
| wake_req_o | output | 1 | One-cycle wake request |
| to_flag_o | output | 1 | Sticky time-out flag |
| osc_req_o | output | 1 | Slow-oscillator enable request |

## Verification
The assertions assume that every strobe input is a single-cycle pulse and that clear strobes never arrive on back-to-back cycles. Without that limit, two early clears in a row would give two adjacent reset pulses. They also assume that the configuration fields change only while reset is held.

The bench drives each strobe for exactly one cycle, with idle cycles between strobes. It changes configuration only before it applies reset. It starts every scenario from a fresh reset.

// File: rtl/lpwd_pkg.sv
package lpwd_pkg;
  // power of two, used for divisors and ratios
  function automatic int unsigned pow2(input int unsigned e);
    return 32'd1 << e;
  endfunction

  // three quarters of a count, rounded down: window start
  function automatic int unsigned quarter3(input int unsigned n);
    return (3 * n) / 4;
  endfunction
endpackage

// File: rtl/lpwd_prescale.sv
module lpwd_prescale #(
  parameter int SHORT_LOG = 5,
  parameter int LONG_LOG  = 7,
  localparam int PRE_W    = LONG_LOG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             long_sel,
  output logic [PRE_W-1:0] cnt,
  output logic             wrap
);
  import lpwd_pkg::*;

  logic [PRE_W-1:0] last;

  always_comb begin
    last = long_sel ? PRE_W'(pow2(LONG_LOG) - 1) : PRE_W'(pow2(SHORT_LOG) - 1);
    wrap = tick && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cnt <= '0;
    else if (tick)
      cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lpwd_postscale.sv
module lpwd_postscale #(
  parameter int SEL_W   = 4,
  localparam int POST_W = (1 << SEL_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [SEL_W-1:0]  sel,
  output logic [POST_W-1:0] cnt,
  output logic              term
);
  import lpwd_pkg::*;

  logic [POST_W-1:0] last;

  always_comb begin
    last = POST_W'(pow2(32'(sel)) - 1);
    term = step && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)
      cnt <= '0;
    else if (step)
      cnt <= term ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/lp_watchdog.sv
module lp_watchdog #(
  parameter int SHORT_LOG = 5,
  parameter int LONG_LOG  = 7,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lp_tick,
  input  logic             cfg_pre_long,
  input  logic [SEL_W-1:0] cfg_post_sel,
  input  logic [1:0]       cfg_en_mode,
  input  logic             cfg_win_dis,
  input  logic             sw_en_we,
  input  logic             sw_en_d,
  input  logic             kick_i,
  input  logic             sleep_enter_i,
  input  logic             sleep_exit_i,
  input  logic             clk_sw_done_i,
  input  logic             flag_clr_i,
  output logic             rst_req_o,
  output logic             wake_req_o,
  output logic             to_flag_o,
  output logic             osc_req_o
);
  import lpwd_pkg::*;

  localparam int PRE_W  = LONG_LOG;
  localparam int POST_W = (1 << SEL_W) - 1;

  // named internal events, observed by the bound checker
  logic              active;
  logic              sw_en_q;
  logic              asleep_q;
  logic              restart_src;
  logic              win_open;
  logic              early_kick;
  logic              expire;
  logic              cnt_clear;
  logic              pre_wrap;
  logic              post_term;
  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;
  logic [PRE_W-1:0]  pre_win;
  logic [POST_W-1:0] post_win;

  lpwd_prescale #(.SHORT_LOG(SHORT_LOG), .LONG_LOG(LONG_LOG)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .tick(lp_tick),
    .long_sel(cfg_pre_long), .cnt(pre_cnt), .wrap(pre_wrap)
  );

  lpwd_postscale #(.SEL_W(SEL_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear), .step(pre_wrap),
    .sel(cfg_post_sel), .cnt(post_cnt), .term(post_term)
  );

  always_comb begin
    active      = (cfg_en_mode == 2'b11) || ((cfg_en_mode == 2'b10) && sw_en_q);
    restart_src = kick_i || sleep_enter_i || sleep_exit_i || clk_sw_done_i;
    pre_win  = cfg_pre_long ? PRE_W'(quarter3(pow2(LONG_LOG)))
                            : PRE_W'(quarter3(pow2(SHORT_LOG)));
    post_win = POST_W'(quarter3(pow2(32'(cfg_post_sel))));
    // a 1:1 ratio has no postscale count to compare, so use the prescaler
    win_open = (cfg_post_sel == '0) ? (pre_cnt >= pre_win) : (post_cnt >= post_win);
    early_kick = active && kick_i && !cfg_win_dis && !win_open;
    expire     = active && post_term && !restart_src;
    cnt_clear  = !active || restart_src || expire;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_en_q    <= 1'b0;
      asleep_q   <= 1'b0;
      rst_req_o  <= 1'b0;
      wake_req_o <= 1'b0;
      to_flag_o  <= 1'b0;
    end else begin
      if (sw_en_we)
        sw_en_q <= sw_en_d;
      if (sleep_enter_i)
        asleep_q <= 1'b1;
      else if (sleep_exit_i)
        asleep_q <= 1'b0;
      rst_req_o  <= early_kick || (expire && !asleep_q);
      wake_req_o <= expire && asleep_q;
      if (early_kick || expire)
        to_flag_o <= 1'b1;
      else if (flag_clr_i)
        to_flag_o <= 1'b0;
    end
  end

  assign osc_req_o = active;
endmodule

// File: rtl/lpwd_checker.sv
module lpwd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_en_mode,
  input logic       flag_clr_i,
  input logic       rst_req_o,
  input logic       wake_req_o,
  input logic       to_flag_o,
  input logic       osc_req_o,
  input logic       asleep_q,
  input logic       expire,
  input logic       early_kick
);
  // R2
  expire_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req_o || wake_req_o));
  // R10
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && wake_req_o));
  // R10
  wake_when_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire && asleep_q |=> wake_req_o && !rst_req_o);
  // R7
  early_kick_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    early_kick |=> rst_req_o && to_flag_o);
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_flag_o && !flag_clr_i |=> to_flag_o);
  // R11
  flag_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o || wake_req_o) |-> to_flag_o);
  // R3
  off_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en_mode[1] |=> !rst_req_o && !wake_req_o);
  // R5
  osc_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en_mode == 2'b11 |-> osc_req_o);
endmodule

bind lp_watchdog lpwd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en_mode(cfg_en_mode), .flag_clr_i(flag_clr_i),
  .rst_req_o(rst_req_o), .wake_req_o(wake_req_o), .to_flag_o(to_flag_o),
  .osc_req_o(osc_req_o), .asleep_q(asleep_q), .expire(expire),
  .early_kick(early_kick)
);

// File: tb/lp_watchdog_test.sv
`timescale 1ns/1ps
module lp_watchdog_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lp_tick = 1'b0;
  logic       cfg_pre_long = 1'b0;
  logic [3:0] cfg_post_sel = 4'd0;
  logic [1:0] cfg_en_mode = 2'b11;
  logic       cfg_win_dis = 1'b1;
  logic       sw_en_we = 1'b0, sw_en_d = 1'b0;
  logic       kick_i = 1'b0, sleep_enter_i = 1'b0, sleep_exit_i = 1'b0;
  logic       clk_sw_done_i = 1'b0, flag_clr_i = 1'b0;
  logic       rst_req_o, wake_req_o, to_flag_o, osc_req_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  lp_watchdog uut (
    .clk(clk), .rst_n(rst_n), .lp_tick(lp_tick), .cfg_pre_long(cfg_pre_long),
    .cfg_post_sel(cfg_post_sel), .cfg_en_mode(cfg_en_mode), .cfg_win_dis(cfg_win_dis),
    .sw_en_we(sw_en_we), .sw_en_d(sw_en_d), .kick_i(kick_i),
    .sleep_enter_i(sleep_enter_i), .sleep_exit_i(sleep_exit_i),
    .clk_sw_done_i(clk_sw_done_i), .flag_clr_i(flag_clr_i),
    .rst_req_o(rst_req_o), .wake_req_o(wake_req_o), .to_flag_o(to_flag_o),
    .osc_req_o(osc_req_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // n ticks; records first cycle index (1-based) of each request and counts
  task automatic run_ticks(input int n, output int first_rst, output int n_rst,
                           output int first_wake, output int n_wake);
    first_rst = 0; n_rst = 0; first_wake = 0; n_wake = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk) lp_tick = 1'b1;
      @(posedge clk); #1;
      if (rst_req_o)  begin n_rst++;  if (first_rst == 0)  first_rst = i;  end
      if (wake_req_o) begin n_wake++; if (first_wake == 0) first_wake = i; end
    end
    @(negedge clk) lp_tick = 1'b0;
  endtask

  // one-cycle kick, returns whether a reset request followed
  task automatic kick(output bit saw);
    @(negedge clk) kick_i = 1'b1;
    @(posedge clk); #1 saw = rst_req_o;
    @(negedge clk) kick_i = 1'b0;
  endtask

  task automatic setup(input bit pl, input int ps, input logic [1:0] md, input bit wd);
    cfg_pre_long = pl; cfg_post_sel = 4'(ps); cfg_en_mode = md; cfg_win_dis = wd;
    do_reset();
  endtask

  task automatic t_reset_state();
    setup(0, 0, 2'b11, 1);
    @(posedge clk); #1;
    // R12
    check("R12 rst_req", rst_req_o, 0);
    check("R12 wake", wake_req_o, 0);
    check("R12 flag", to_flag_o, 0);
  endtask

  task automatic t_prescale();
    int fr, nr, fw, nw;
    setup(0, 0, 2'b11, 1);
    run_ticks(40, fr, nr, fw, nw);
    check("R1 short period", fr, 32);
    check("R2 single pulse", nr, 1);
    setup(1, 0, 2'b11, 1);
    run_ticks(130, fr, nr, fw, nw);
    check("R1 long period", fr, 128);
  endtask

  task automatic t_postscale();
    int fr, nr, fw, nw;
    setup(0, 2, 2'b11, 1);
    run_ticks(140, fr, nr, fw, nw);
    check("R2 ratio 4", fr, 128);
    setup(1, 3, 2'b11, 1);
    run_ticks(2100, fr, nr, fw, nw);
    check("R2 ratio 8 first", fr, 1024);
    check("R2 restart after timeout", nr, 2);
  endtask

  task automatic t_modes();
    int fr, nr, fw, nw;
    setup(0, 0, 2'b00, 1);
    run_ticks(100, fr, nr, fw, nw);
    check("R3 mode 00 no req", nr, 0);
    check("R5 mode 00 osc", osc_req_o, 0);
    setup(0, 0, 2'b01, 1);
    run_ticks(100, fr, nr, fw, nw);
    check("R3 mode 01 no req", nr, 0);
    setup(0, 0, 2'b10, 1);
    run_ticks(100, fr, nr, fw, nw);
    check("R3 mode 10 sw off", nr, 0);
    check("R5 sw off osc", osc_req_o, 0);
    @(negedge clk) begin sw_en_we = 1'b1; sw_en_d = 1'b1; end
    @(negedge clk) sw_en_we = 1'b0;
    check("R4 sw write osc", osc_req_o, 1);
    run_ticks(40, fr, nr, fw, nw);
    check("R3 mode 10 sw on", fr, 32);
    do_reset();
    #1 check("R4 sw cleared by reset", osc_req_o, 0);
  endtask

  task automatic t_restart();
    int fr, nr, fw, nw;
    bit saw;
    setup(0, 0, 2'b11, 1);
    run_ticks(20, fr, nr, fw, nw);
    @(negedge clk) clk_sw_done_i = 1'b1;
    @(negedge clk) clk_sw_done_i = 1'b0;
    run_ticks(40, fr, nr, fw, nw);
    check("R6 clock switch restart", fr, 32);
    setup(0, 0, 2'b11, 1);
    run_ticks(25, fr, nr, fw, nw);
    @(negedge clk) sleep_exit_i = 1'b1;
    @(negedge clk) sleep_exit_i = 1'b0;
    run_ticks(40, fr, nr, fw, nw);
    check("R6 sleep exit restart", fr, 32);
    setup(0, 0, 2'b11, 1);
    run_ticks(10, fr, nr, fw, nw);
    kick(saw);
    check("R9 early kick no window", saw, 0);
    run_ticks(40, fr, nr, fw, nw);
    check("R6 kick restart", fr, 32);
  endtask

  task automatic t_window();
    int fr, nr, fw, nw;
    bit saw;
    setup(0, 2, 2'b11, 0);
    run_ticks(95, fr, nr, fw, nw);
    kick(saw);
    check("R7 kick before 3/4", saw, 1);
    check("R7 flag set", to_flag_o, 1);
    setup(0, 2, 2'b11, 0);
    run_ticks(96, fr, nr, fw, nw);
    kick(saw);
    check("R7 kick at 3/4", saw, 0);
    run_ticks(130, fr, nr, fw, nw);
    check("R7 accepted kick restarts", fr, 128);
    setup(0, 0, 2'b11, 0);
    run_ticks(23, fr, nr, fw, nw);
    kick(saw);
    check("R8 1:1 tick 23", saw, 1);
    setup(0, 0, 2'b11, 0);
    run_ticks(24, fr, nr, fw, nw);
    kick(saw);
    check("R8 1:1 tick 24", saw, 0);
    setup(1, 0, 2'b11, 0);
    run_ticks(95, fr, nr, fw, nw);
    kick(saw);
    check("R8 long tick 95", saw, 1);
  endtask

  task automatic t_sleep_flag();
    int fr, nr, fw, nw;
    setup(0, 0, 2'b11, 1);
    @(negedge clk) sleep_enter_i = 1'b1;
    @(negedge clk) sleep_enter_i = 1'b0;
    run_ticks(40, fr, nr, fw, nw);
    check("R10 wake time", fw, 32);
    check("R10 no reset asleep", nr, 0);
    check("R11 flag after wake", to_flag_o, 1);
    repeat (20) @(negedge clk);
    check("R11 flag holds", to_flag_o, 1);
    @(negedge clk) flag_clr_i = 1'b1;
    @(negedge clk) flag_clr_i = 1'b0;
    check("R11 flag cleared", to_flag_o, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog: actual %0d expected <150000", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    t_reset_state();
    t_prescale();
    t_postscale();
    t_modes();
    t_restart();
    t_window();
    t_sleep_flag();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule